// File: doc/BRIEF.md
# Serial Stereo Audio Receiver

This block takes two-channel PCM audio from a serial data line that comes with its own bit clock and a left/right channel clock. Each bit is shifted into a serial-to-parallel register. A transition of the channel clock commits the bits gathered so far. A falling transition stores them as the left sample. A rising transition stores them as the right sample and completes the stereo pair.

The whole receive side runs on the incoming bit clock. The completed pair is passed to a processing domain on an unrelated system clock. The hand-over uses a toggle flag that passes through a synchroniser. The system side then shows both channels at once, together with a one-cycle new-sample strobe. Because of this, jitter or phase drift on the input clocks never reaches the timing of the system side.

Samples are two's complement and arrive MSB first. The input word length is 16 or 18 bits, chosen by a static select input. The word is aligned to the end of its slot, just before the channel clock transition, so extra leading bits in a longer slot are discarded. Results are always 18 bits wide. A 16-bit sample sits in the upper bits with zeros below it.

Top module: `srx_stereo_rx`

## Requirements
- R1: `din` is sampled on each rising edge of `bclk`; the first bit of a word is its MSB and samples are two's complement, delivered unchanged in value.
- R2: The bits shifted before a high-to-low change of `lrclk` form the left sample. The bits shifted before a low-to-high change form the right sample. The channel change is seen at the first `bclk` rising edge after it, and the bit taken at that same edge belongs to the next word.
- R3: Only the last N bits shifted before the channel change are kept, where N is the selected length. Any earlier bits in the slot have no effect on the result.
- R4: With `wl_long` = 1 (18-bit mode), `smp_left`/`smp_right` equal the 18 received bits.
- R5: With `wl_long` = 0 (16-bit mode), bits [17:2] hold the 16 received bits and bits [1:0] are zero.
- R6: After each low-to-high change of `lrclk` that completes a pair, `smp_valid` pulses for one `sys_clk` cycle within 20 `sys_clk` cycles. In that same cycle both `smp_left` and `smp_right` take the new pair.
- R7: `smp_valid` is never high on two consecutive cycles. `smp_left` and `smp_right` do not change in any cycle where `smp_valid` is low.
- R8: After reset, no pair is delivered until a left sample has been committed by a high-to-low change of `lrclk`. A low-to-high change seen before that produces no pulse.
- R9: While `sys_rst` is high, and afterwards until the first pulse, `smp_valid` is 0 and both sample outputs are 0.
- R10: Exactly one `smp_valid` pulse is produced per completed left/right frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Processing-domain clock |
| sys_rst | input | 1 | Synchronous active-high reset, `sys_clk` domain |
| bclk | input | 1 | Serial bit clock; data sampled on its rising edge |
| bclk_rst | input | 1 | Synchronous active-high reset, `bclk` domain |
| din | input | 1 | Serial audio data, MSB first |
| lrclk | input | 1 | Channel clock; high during the left slot, low during the right slot |
| wl_long | input | 1 | Word length select: 1 = 18 bits, 0 = 16 bits (static) |
| smp_left | output | 18 | Left sample of the latest pair |
| smp_right | output | 18 | Right sample of the latest pair |
| smp_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
The frames use extreme words: the most positive value, the most negative value, all ones and a lone LSB. These expose bit-order reversal, sign damage and one-bit slips at the start or end of a word. Random words in both modes confirm that left and right are not swapped. Slots wider than the word are filled with random leading bits, which shows that the kept bits are aligned to the channel change and not to the slot start. Running the same words in 16-bit mode separates correct zero-filling of the low bits from a shifted or truncated placement. The very first channel transition after reset is a low-to-high change with no left word before it, which shows that an unarmed receiver delivers nothing.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_LONG_W  = 18;
  localparam int SRX_SHORT_W = 16;

  typedef logic [SRX_LONG_W-1:0] srx_word_t;

  typedef struct packed {
    srx_word_t left;
    srx_word_t right;
  } srx_pair_t;
endpackage

// File: rtl/srx_shift_in.sv
module srx_shift_in
  import srx_pkg::*;
#(
  parameter int LONG_W  = SRX_LONG_W,
  parameter int SHORT_W = SRX_SHORT_W
) (
  input  logic      bclk,
  input  logic      bclk_rst,
  input  logic      din,
  input  logic      lrclk,
  input  logic      wl_long,
  output srx_pair_t pair_o,
  output logic      pair_tgl_o
);
  localparam int PAD_W = LONG_W - SHORT_W;

  logic [LONG_W-1:0] shreg;
  logic [LONG_W-1:0] word_fmt;
  logic [LONG_W-1:0] left_hold;
  logic              lr_q;
  logic              armed;
  logic              lr_rise;
  logic              lr_fall;
  srx_pair_t         pair_q;
  logic              tgl_q;

  // Right-justified word: keep only the newest bits, pad short words below
  always_comb begin
    if (wl_long) word_fmt = shreg;
    else         word_fmt = {shreg[SHORT_W-1:0], {PAD_W{1'b0}}};
  end

  assign lr_rise = lrclk & ~lr_q;
  assign lr_fall = ~lrclk & lr_q;

  always_ff @(posedge bclk) begin
    if (bclk_rst) begin
      shreg     <= '0;
      lr_q      <= 1'b0;
      armed     <= 1'b0;
      left_hold <= '0;
      pair_q    <= '0;
      tgl_q     <= 1'b0;
    end else begin
      shreg <= {shreg[LONG_W-2:0], din};
      lr_q  <= lrclk;
      if (lr_fall) begin
        left_hold <= word_fmt;
        armed     <= 1'b1;
      end
      if (lr_rise && armed) begin
        pair_q.left  <= left_hold;
        pair_q.right <= word_fmt;
        tgl_q        <= ~tgl_q;
      end
    end
  end

  assign pair_o     = pair_q;
  assign pair_tgl_o = tgl_q;

  // R2: the hand-over flag only moves on a low-to-high channel change
  p_tgl_on_rise_r2: assert property (@(posedge bclk) disable iff (bclk_rst)
    (tgl_q != $past(tgl_q)) |-> ($past(lrclk) && !$past(lr_q)));

  // R2: left storage only changes on a high-to-low channel change
  p_left_on_fall_r2: assert property (@(posedge bclk) disable iff (bclk_rst)
    (left_hold != $past(left_hold)) |-> (!$past(lrclk) && $past(lr_q)));

  // R5: a short word committed as right sample has zero low bits
  p_short_pad_r5: assert property (@(posedge bclk) disable iff (bclk_rst)
    (lr_rise && armed && !wl_long) |=> (pair_q.right[PAD_W-1:0] == '0));
endmodule

// File: rtl/srx_bit_sync.sv
module srx_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_pair_xfer.sv
module srx_pair_xfer
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      sys_clk,
  input  logic      sys_rst,
  input  srx_pair_t pair_i,
  input  logic      tgl_i,
  output srx_pair_t pair_o,
  output logic      valid_o
);
  logic      tgl_s;
  logic      tgl_seen;
  srx_pair_t pair_q;
  logic      valid_q;

  srx_bit_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (sys_clk),
    .rst (sys_rst),
    .d   (tgl_i),
    .q   (tgl_s)
  );

  // pair_i has been stable for SYNC_STAGES cycles when the flag edge arrives
  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      tgl_seen <= 1'b0;
      pair_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      tgl_seen <= tgl_s;
      valid_q  <= tgl_s ^ tgl_seen;
      if (tgl_s ^ tgl_seen) pair_q <= pair_i;
    end
  end

  assign pair_o  = pair_q;
  assign valid_o = valid_q;

  // R7: strobe lasts exactly one cycle
  p_single_pulse_r7: assert property (@(posedge sys_clk) disable iff (sys_rst)
    valid_q |=> !valid_q);

  // R7: outputs hold between strobes
  p_hold_between_r7: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !valid_q |-> $stable(pair_q));
endmodule

// File: rtl/srx_stereo_rx.sv
module srx_stereo_rx
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  sys_clk,
  input  logic                  sys_rst,
  input  logic                  bclk,
  input  logic                  bclk_rst,
  input  logic                  din,
  input  logic                  lrclk,
  input  logic                  wl_long,
  output logic [SRX_LONG_W-1:0] smp_left,
  output logic [SRX_LONG_W-1:0] smp_right,
  output logic                  smp_valid
);
  srx_pair_t bk_pair;
  logic      bk_tgl;
  srx_pair_t sy_pair;

  srx_shift_in #(
    .LONG_W  (SRX_LONG_W),
    .SHORT_W (SRX_SHORT_W)
  ) shift_i (
    .bclk       (bclk),
    .bclk_rst   (bclk_rst),
    .din        (din),
    .lrclk      (lrclk),
    .wl_long    (wl_long),
    .pair_o     (bk_pair),
    .pair_tgl_o (bk_tgl)
  );

  srx_pair_xfer #(
    .SYNC_STAGES (SYNC_STAGES)
  ) xfer_i (
    .sys_clk (sys_clk),
    .sys_rst (sys_rst),
    .pair_i  (bk_pair),
    .tgl_i   (bk_tgl),
    .pair_o  (sy_pair),
    .valid_o (smp_valid)
  );

  assign smp_left  = sy_pair.left;
  assign smp_right = sy_pair.right;
endmodule

// File: tb/srx_stereo_rx_tb_top.sv
module srx_stereo_rx_tb_top;
  localparam int SYS_PERIOD = 10;
  localparam int BCLK_HALF  = 60;
  localparam int LAT_LIMIT  = 20;

  logic        sys_clk  = 1'b0;
  logic        sys_rst  = 1'b1;
  logic        bclk     = 1'b0;
  logic        bclk_rst = 1'b1;
  logic        din      = 1'b0;
  logic        lrclk    = 1'b1;
  logic        wl_long  = 1'b1;
  logic [17:0] smp_left;
  logic [17:0] smp_right;
  logic        smp_valid;

  int          n_vec = 0;
  int          n_bad = 0;
  logic [35:0] exp_q[$];
  string       tag_q[$];
  logic        pending = 1'b0;
  logic [35:0] pend_val;
  string       pend_tag;
  int          wait_cnt = 0;
  logic [17:0] last_l = '0;
  logic [17:0] last_r = '0;
  logic        prev_valid = 1'b0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  srx_stereo_rx dut_i (
    .sys_clk   (sys_clk),
    .sys_rst   (sys_rst),
    .bclk      (bclk),
    .bclk_rst  (bclk_rst),
    .din       (din),
    .lrclk     (lrclk),
    .wl_long   (wl_long),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .smp_valid (smp_valid)
  );

  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;
  always #(BCLK_HALF)    bclk    = ~bclk;

  task automatic report_fail(input string req, input logic [35:0] got, input logic [35:0] want);
    n_bad++;
    $display("FAIL %s: actual %h expected %h at %0t", req, got, want, $time);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  function automatic logic [17:0] model_word(input logic [17:0] w, input logic lng);
    if (lng) return w;
    return {w[15:0], 2'b00};
  endfunction

  // Drive one channel slot; word bits go last so they end at the channel change
  task automatic drive_half(input logic lr, input logic [17:0] w, input int nbits, input int slot);
    for (int i = slot - 1; i >= 0; i--) begin
      @(negedge bclk);
      lrclk = lr;
      din   = (i < nbits) ? w[i] : 1'($urandom_range(0, 1));
      if (lr && (i == slot - 1) && pending) begin
        exp_q.push_back(pend_val);
        tag_q.push_back(pend_tag);
        pending = 1'b0;
      end
    end
  endtask

  task automatic send_frame(input logic [17:0] l, input logic [17:0] r, input int slot);
    int nb;
    nb = wl_long ? 18 : 16;
    drive_half(1'b1, l, nb, slot);
    drive_half(1'b0, r, nb, slot);
    pend_val = {model_word(l, wl_long), model_word(r, wl_long)};
    pend_tag = wl_long ? ((slot > nb) ? "R1/R2/R3/R4" : "R1/R2/R4")
                       : ((slot > nb) ? "R1/R2/R3/R5" : "R1/R2/R5");
    pending  = 1'b1;
  endtask

  task automatic close_frame;
    @(negedge bclk);
    lrclk = 1'b1;
    din   = 1'b0;
    if (pending) begin
      exp_q.push_back(pend_val);
      tag_q.push_back(pend_tag);
      pending = 1'b0;
    end
    repeat (4) @(negedge bclk);
  endtask

  // Reference comparison on every system clock
  always @(negedge sys_clk) begin
    if (mon_on) begin
      n_vec++;
      if (smp_valid && prev_valid)
        report_fail("R7 double strobe", 36'(1), 36'(0));
      if (smp_valid) begin
        if (exp_q.size() == 0) begin
          report_fail("R8/R10 unexpected strobe", {smp_left, smp_right}, '0);
        end else begin
          logic [35:0] want;
          string       t;
          want = exp_q.pop_front();
          t    = tag_q.pop_front();
          if ({smp_left, smp_right} !== want)
            report_fail({t, "/R6 pair value"}, {smp_left, smp_right}, want);
        end
        wait_cnt = 0;
      end else begin
        if (smp_left !== last_l || smp_right !== last_r)
          report_fail("R7 outputs moved without strobe", {smp_left, smp_right}, {last_l, last_r});
        if (exp_q.size() > 0) begin
          wait_cnt++;
          if (wait_cnt > LAT_LIMIT) begin
            report_fail("R6 strobe late", 36'(wait_cnt), 36'(LAT_LIMIT));
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
            wait_cnt = 0;
          end
        end
      end
      last_l     = smp_left;
      last_r     = smp_right;
      prev_valid = smp_valid;
    end
  end

  initial begin
    #(SYS_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge bclk);
    // R9: reset state
    @(negedge sys_clk);
    n_vec++;
    if (smp_valid !== 1'b0 || smp_left !== '0 || smp_right !== '0)
      report_fail("R9 reset state", {smp_left, smp_right}, '0);
    @(negedge sys_clk);
    sys_rst = 1'b0;
    @(negedge bclk);
    bclk_rst = 1'b0;
    mon_on   = 1'b1;
    // R8: lrclk high at release looks like a rise with no left word yet
    repeat (6) @(negedge bclk);
    n_vec++;
    if (smp_left !== '0 || smp_right !== '0)
      report_fail("R8/R9 idle after reset", {smp_left, smp_right}, '0);

    // 18-bit mode, exact slots: R4 extremes
    wl_long = 1'b1;
    send_frame(18'h1FFFF, 18'h20000, 18);
    send_frame(18'h3FFFF, 18'h00001, 18);
    send_frame(18'(($urandom)), 18'(($urandom)), 18);
    send_frame(18'h2AAAA, 18'h15555, 18);
    // R3: wider slots with random leading bits
    send_frame(18'h00001, 18'h3FFFE, 22);
    send_frame(18'(($urandom)), 18'(($urandom)), 20);
    send_frame(18'h20000, 18'h1FFFF, 24);
    close_frame();

    // 16-bit mode: R5
    wl_long = 1'b0;
    send_frame(18'h08000, 18'h07FFF, 16);
    send_frame(18'h0FFFF, 18'h00001, 16);
    send_frame(18'(($urandom)), 18'(($urandom)), 16);
    send_frame(18'h01234, 18'h0FEDC, 20);
    send_frame(18'h08001, 18'h07FFE, 24);
    close_frame();

    repeat (40) @(negedge sys_clk);
    // R10: every completed frame produced its strobe
    n_vec++;
    if (exp_q.size() != 0)
      report_fail("R10 missing strobes", 36'(exp_q.size()), '0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule